// File: doc/BRIEF.md
# Windowed Register Index Mapper

This block translates a 5-bit architectural integer register number into an index into a flat physical register file. The physical file is laid out as several banks of eight globals, followed by a ring of register windows of sixteen entries each, followed by a small set of microcode scratch registers. Two pieces of architectural state steer the translation. The window pointer picks the position in the ring. The global level picks the bank of globals.

A lookup names a view: the current window, the next window (pointer minus one), the previous window (pointer plus one), or the scratch area. The caller can then resolve operands of an upcoming save or restore before the pointer moves. Adjacent windows share eight registers, because the ring is computed with modular arithmetic. The window pointer and the global level each have a write port that clamps out-of-range values. The result is registered and appears one clock after the request.

Top module: `win_reg_map`

## Requirements
- R1: Architectural register 0 maps to physical index 0 in every view except the scratch view (view_sel 2'b11), whatever the global level.
- R2: Architectural registers 1 to 7 map to `r + 8*GL`. The result is the same in the current (2'b00), next (2'b01) and previous (2'b10) views.
- R3: Architectural registers 8 to 31, taken as i = r - 8, map to `TG + ((i - 16*W) mod TW)`, where TG = 8*NGSETS and TW = 16*NWIN. In the current view W is the window pointer.
- R4: The next view (2'b01) uses W = (CWP - 1) mod NWIN. The previous view (2'b10) uses W = (CWP + 1) mod NWIN. Both wrap around the ring.
- R5: Registers 8 to 15 of window w reach the same physical index as registers 24 to 31 of window (w + 1) mod NWIN. This includes the wrap from the last window to window 0.
- R6: The scratch view (2'b11) maps register r to `TG + TW + (r mod NMICRO)`.
- R7: A window pointer write stores NWIN-1 when the written value is NWIN or more, and stores the value itself otherwise. The pointer holds when not written.
- R8: A global level write stores NGSETS-1 when the written value is NGSETS or more, and stores the value itself otherwise. The level holds when not written.
- R9: While reset is asserted, the window pointer, the global level and the physical index are all 0.
- R10: phys_idx is registered. It reflects the request and the pointer and level held before the same clock edge, so a lookup issued together with a write still uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cwp_we | input | 1 | Window pointer write strobe |
| cwp_wdata | input | WD_W | Window pointer write value |
| gl_we | input | 1 | Global level write strobe |
| gl_wdata | input | WD_W | Global level write value |
| view_sel | input | 2 | 00 current, 01 next, 10 previous, 11 scratch |
| arch_reg | input | 5 | Architectural register number |
| phys_idx | output | PW | Physical index, one cycle after the request |
| cur_cwp | output | CW | Stored window pointer |
| cur_gl | output | GW | Stored global level |

## Verification
The bench uses the default parameters: eight windows, four global banks and eight scratch registers, which give a ring of 128 entries after 32 globals. With these values both ring wraps are reachable. Window 0 viewed as next lands on window 7, and window 7 viewed as previous lands on window 0. Write values such as 200 and 9 exercise both clamps. Register 13 in the scratch view exercises the modulo fold of the scratch index.

// File: rtl/win_reg_map.sv
module win_reg_map #(
  parameter int NWIN   = 8,
  parameter int NGSETS = 4,
  parameter int NMICRO = 8,
  parameter int WD_W   = 8,
  localparam int RPW   = 16,
  localparam int GPS   = 8,
  localparam int TG    = GPS * NGSETS,
  localparam int TW    = RPW * NWIN,
  localparam int NPHYS = TG + TW + NMICRO,
  localparam int PW    = $clog2(NPHYS),
  localparam int CW    = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int GW    = (NGSETS > 1) ? $clog2(NGSETS) : 1,
  localparam int MW    = (NMICRO > 1) ? $clog2(NMICRO) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cwp_we,
  input  logic [WD_W-1:0] cwp_wdata,
  input  logic            gl_we,
  input  logic [WD_W-1:0] gl_wdata,
  input  logic [1:0]      view_sel,
  input  logic [4:0]      arch_reg,
  output logic [PW-1:0]   phys_idx,
  output logic [CW-1:0]   cur_cwp,
  output logic [GW-1:0]   cur_gl
);

  logic [CW-1:0] cwp_q;
  logic [GW-1:0] gl_q;
  logic [PW-1:0] idx_q;

  function automatic logic [PW-1:0] ring_map(input logic [4:0] i, input logic [CW-1:0] w);
    int s;
    s = int'(i) + TW - int'(w) * RPW;
    if (s >= TW) s = s - TW;
    return PW'(TG + s);
  endfunction

  logic [CW-1:0] w_cur, w_nxt, w_prv;
  assign w_cur = cwp_q;
  assign w_nxt = (int'(cwp_q) == 0) ? CW'(NWIN - 1) : CW'(cwp_q - 1'b1);
  assign w_prv = (int'(cwp_q) == NWIN - 1) ? CW'(0) : CW'(cwp_q + 1'b1);

  logic [CW-1:0] w_view [3];
  assign w_view[0] = w_cur;
  assign w_view[1] = w_nxt;
  assign w_view[2] = w_prv;

  logic [4:0]    win_i;
  logic [PW-1:0] glob_idx, micro_idx;
  logic [PW-1:0] view_idx [3];

  assign win_i     = arch_reg - 5'd8;
  assign glob_idx  = (arch_reg == 5'd0) ? '0 : PW'(int'(arch_reg) + GPS * int'(gl_q));
  assign micro_idx = PW'(TG + TW + int'(arch_reg[MW-1:0]));

  for (genvar v = 0; v < 3; v++) begin : g_view
    assign view_idx[v] = (arch_reg < 5'd8) ? glob_idx : ring_map(win_i, w_view[v]);
  end

  logic [PW-1:0] idx_d;
  always_comb begin
    case (view_sel)
      2'b00:   idx_d = view_idx[0];
      2'b01:   idx_d = view_idx[1];
      2'b10:   idx_d = view_idx[2];
      default: idx_d = micro_idx;
    endcase
  end

  logic [CW-1:0] cwp_clamped;
  logic [GW-1:0] gl_clamped;
  assign cwp_clamped = (int'(cwp_wdata) >= NWIN)   ? CW'(NWIN - 1)   : CW'(cwp_wdata);
  assign gl_clamped  = (int'(gl_wdata)  >= NGSETS) ? GW'(NGSETS - 1) : GW'(gl_wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp_q <= '0;
      gl_q  <= '0;
      idx_q <= '0;
    end else begin
      idx_q <= idx_d;
      if (cwp_we) cwp_q <= cwp_clamped;
      if (gl_we)  gl_q  <= gl_clamped;
    end
  end

  assign phys_idx = idx_q;
  assign cur_cwp  = cwp_q;
  assign cur_gl   = gl_q;

endmodule

// File: rtl/win_reg_map_chk.sv
module win_reg_map_chk #(
  parameter int NWIN   = 8,
  parameter int NGSETS = 4,
  parameter int WD_W   = 8,
  parameter int PW     = 8,
  parameter int CW     = 3,
  parameter int GW     = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cwp_we,
  input logic [WD_W-1:0] cwp_wdata,
  input logic            gl_we,
  input logic [WD_W-1:0] gl_wdata,
  input logic [1:0]      view_sel,
  input logic [4:0]      arch_reg,
  input logic [PW-1:0]   phys_idx,
  input logic [CW-1:0]   cur_cwp,
  input logic [GW-1:0]   cur_gl
);
  localparam int TG = 8 * NGSETS;
  localparam int TW = 16 * NWIN;

  // R7
  cwp_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cwp_we && int'(cwp_wdata) >= NWIN) |=> (int'(cur_cwp) == NWIN - 1));

  // R7
  cwp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cwp_we |=> $stable(cur_cwp));

  // R8
  gl_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gl_we && int'(gl_wdata) >= NGSETS) |=> (int'(cur_gl) == NGSETS - 1));

  // R1
  g0_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (view_sel != 2'b11 && arch_reg == 5'd0) |=> (phys_idx == '0));

  // R3
  win_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (view_sel != 2'b11 && arch_reg >= 5'd8) |=> (int'(phys_idx) >= TG && int'(phys_idx) < TG + TW));
endmodule

bind win_reg_map win_reg_map_chk #(
  .NWIN(NWIN), .NGSETS(NGSETS), .WD_W(WD_W), .PW(PW), .CW(CW), .GW(GW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cwp_we(cwp_we), .cwp_wdata(cwp_wdata),
  .gl_we(gl_we), .gl_wdata(gl_wdata), .view_sel(view_sel), .arch_reg(arch_reg),
  .phys_idx(phys_idx), .cur_cwp(cur_cwp), .cur_gl(cur_gl)
);

// File: tb/win_reg_map_test.sv
module win_reg_map_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       cwp_we = 0, gl_we = 0;
  logic [7:0] cwp_wdata = 0, gl_wdata = 0;
  logic [1:0] view_sel = 0;
  logic [4:0] arch_reg = 0;
  logic [7:0] phys_idx;
  logic [2:0] cur_cwp;
  logic [1:0] cur_gl;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  win_reg_map uut (
    .clk(clk), .rst_n(rst_n), .cwp_we(cwp_we), .cwp_wdata(cwp_wdata),
    .gl_we(gl_we), .gl_wdata(gl_wdata), .view_sel(view_sel), .arch_reg(arch_reg),
    .phys_idx(phys_idx), .cur_cwp(cur_cwp), .cur_gl(cur_gl)
  );

  localparam int NV = 18;
  localparam int    T_CWP [NV] = '{0, 0, 0, 0, 0, 0, 1, 1, 0, 7, 7, 3, 3, 2, 2, 2, 1, 2};
  localparam int    T_GL  [NV] = '{0, 0, 3, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 2, 2, 0, 0};
  localparam int    T_VW  [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 2, 0, 1, 2, 0, 1, 2, 0, 0};
  localparam int    T_REG [NV] = '{0, 5, 0, 7, 8, 31, 8, 31, 8, 8, 8, 20, 31, 3, 1, 0, 8, 24};
  localparam int    T_EXP [NV] = '{0, 5, 0, 31, 32, 55, 144, 39, 48, 32, 48, 140, 119, 11, 17, 0, 144, 144};
  localparam string T_REQ [NV] = '{"R1", "R2", "R1", "R2", "R3", "R3", "R3", "R3", "R4", "R4",
                                   "R3", "R4", "R4", "R2", "R2", "R1", "R5", "R5"};

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic cfg(int c, int g);
    @(negedge clk);
    cwp_we = 1; cwp_wdata = 8'(c);
    gl_we  = 1; gl_wdata  = 8'(g);
    @(negedge clk);
    cwp_we = 0; gl_we = 0;
  endtask

  task automatic look(int v, int r, output int got);
    view_sel = 2'(v); arch_reg = 5'(r);
    @(negedge clk);
    got = int'(phys_idx);
  endtask

  int got, a, b;

  initial begin
    #20;
    @(negedge clk);
    // R9
    chk("R9 cwp", int'(cur_cwp), 0);
    chk("R9 gl", int'(cur_gl), 0);
    chk("R9 idx", int'(phys_idx), 0);
    rst_n = 1;

    for (int k = 0; k < NV; k++) begin
      cfg(T_CWP[k], T_GL[k]);
      look(T_VW[k], T_REG[k], got);
      chk(T_REQ[k], got, T_EXP[k]);
    end

    // R5 wrap: outs of window 7 against ins of window 0
    cfg(7, 0); look(0, 8, a);
    cfg(0, 0); look(0, 24, b);
    chk("R5 wrap", a, b);
    chk("R5 wrap value", a, 48);

    // R6
    look(3, 5, got);  chk("R6", got, 165);
    look(3, 13, got); chk("R6 fold", got, 165);
    look(3, 0, got);  chk("R6 r0", got, 160);

    // R7
    cfg(200, 0); chk("R7 clamp", int'(cur_cwp), 7);
    look(0, 8, got); chk("R7 clamped lookup", got, 48);
    cfg(8, 0); chk("R7 edge", int'(cur_cwp), 7);
    cfg(6, 0); chk("R7 in range", int'(cur_cwp), 6);
    look(0, 0, got); chk("R7 hold", int'(cur_cwp), 6);

    // R8
    cfg(0, 9); chk("R8 sat", int'(cur_gl), 3);
    cfg(0, 4); chk("R8 edge", int'(cur_gl), 3);
    cfg(0, 2); chk("R8 in range", int'(cur_gl), 2);
    look(0, 7, got); chk("R8 lookup", got, 23);

    // R10: lookup issued with a write uses the old pointer
    cfg(0, 0);
    cwp_we = 1; cwp_wdata = 8'd1;
    view_sel = 2'b00; arch_reg = 5'd8;
    @(negedge clk);
    cwp_we = 0;
    chk("R10 old", int'(phys_idx), 32);
    @(negedge clk);
    chk("R10 new", int'(phys_idx), 144);

    // R9 reset mid-run
    rst_n = 0;
    #1;
    chk("R9 async cwp", int'(cur_cwp), 0);
    chk("R9 async idx", int'(phys_idx), 0);
    rst_n = 1;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule